// File: doc/BRIEF.md
# Burst Column Order Sequencer

The sequencer turns one accepted read or write command into eight consecutive beats. Each beat carries a 3-bit column index, a flag that says whether it carries data, and a flag that says whether the device output driver is on. The order of the indices depends on four things: the starting column bits of the command, a sequential or interleaved setting, a length setting, and whether the command is a read or a write. The length setting can fix every burst at eight beats, fix every burst at a chop of four, or leave the choice to a per-command level. A separate mode-load strobe writes the length and order settings. A command latches these settings when it is accepted, so a later load never changes a burst that is already running.

Commands arrive on a valid/ready handshake. `cmd_ready` is high while the sequencer is idle and during the final beat of a burst, so bursts can run back to back with no gap. A command offered while `cmd_ready` is low is not held for a later cycle. It is dropped, and `cmd_err` pulses in the following cycle, so the source must keep `cmd_valid` low until ready returns. The beat outputs have no ready input: once a burst starts, its beats run at one per clock. The `wr_start` flag marks the beat where the internal write begins. For a write whose chop is fixed by the mode setting it comes two beats earlier than for every other write.

Top module: `burst_order_seq`

## Requirements
- R1: `mode_load` high at a clock edge stores `mode_len` and `mode_interleave`. Length codes: 00 fixed eight, 01 per-command, 10 fixed chop-four, 11 treated as fixed eight. Order: 0 sequential, 1 interleaved. A command uses the settings stored before its acceptance edge.
- R2: In per-command mode, `cmd_bl8` high selects eight beats and low selects chop-four.
- R3: Sequential eight-beat read starting at column c: beat i (0..7) has index {c[2]^i[2], (c[1:0]+i[1:0]) mod 4}. For c=5 this gives 5,6,7,4,1,2,3,0.
- R4: Interleaved eight-beat read: beat i has index c XOR i. For c=5 this gives 5,4,7,6,1,0,3,2.
- R5: A chop-four read gives beats 0..3 of the matching eight-beat read order. Beats 4..7 have `beat_data`=0, `beat_drive`=0 and `beat_col`=0.
- R6: An eight-beat write gives indices 0,1,2,3,4,5,6,7 whatever the command column.
- R7: A chop-four write gives {c[2], i[1:0]} on beats 0..3, so 0..3 or 4..7, with c[1:0] ignored. Beats 4..7 have `beat_data`=0 and `beat_col`=0.
- R8: An accepted burst holds `beat_valid` high for exactly eight cycles, starting the cycle after the acceptance edge. `beat_last` is high on the eighth of these cycles. `beat_drive` is high only on read beats that carry data, and is never high on a write.
- R9: `wr_start` is high for exactly one beat of every write and for no beat of a read: beat 4 normally, and beat 2 when the chop comes from length code 10.
- R10: `cmd_ready` is high when idle and on the final beat. A command accepted on the final beat starts its beat 0 in the very next cycle.
- R11: A command offered while `cmd_ready` is low does not change the running burst, and it raises `cmd_err` for one cycle in the next cycle.
- R12: Synchronous active-high `rst` stores fixed eight and sequential, and leaves the sequencer idle: `beat_valid`=0, `beat_drive`=0, `cmd_ready`=1, `cmd_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | Store length and order settings |
| mode_len | input | 2 | Length code |
| mode_interleave | input | 1 | 1 = interleaved order |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command will be accepted this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_col | input | 3 | Starting column low bits |
| cmd_bl8 | input | 1 | Per-command length level (1 = eight) |
| cmd_err | output | 1 | Pulse: command dropped while busy |
| beat_valid | output | 1 | A burst beat is present |
| beat_col | output | 3 | Column index of this beat |
| beat_data | output | 1 | Beat carries data |
| beat_drive | output | 1 | Output driver enabled |
| beat_last | output | 1 | Final beat of the burst |
| wr_start | output | 1 | Internal write start marker |

## Verification
The assertions check the following on every cycle. Drive never appears outside a burst or on a beat that carries no data, and such beats show index 0. A burst ends only after its last beat, and ready is high on that last beat. A dropped command leaves the beat counter advancing normally. Stored settings change only on a load. Interleaved read indices XOR back to the start column, and sequential read indices step by one in their low bits. Only the bench scenarios can show the following: the full index sequence for every start column under every order and length choice, the exact beat of the write-start marker in each length mode, back-to-back acceptance on the final beat, and a settings load in the middle of a burst that takes effect only on the next command.

// File: rtl/bos_pkg.sv
package bos_pkg;
  typedef enum logic [1:0] {
    LEN_FIX8 = 2'b00,
    LEN_OTF  = 2'b01,
    LEN_FIX4 = 2'b10,
    LEN_RSVD = 2'b11
  } len_mode_e;

  typedef enum logic {
    ORD_SEQ   = 1'b0,
    ORD_INTLV = 1'b1
  } ord_e;

  // Decide whether a command runs as a half-length burst.
  function automatic logic resolve_chop(len_mode_e m, logic bl8_level);
    case (m)
      LEN_FIX4: resolve_chop = 1'b1;
      LEN_OTF:  resolve_chop = ~bl8_level;
      default:  resolve_chop = 1'b0;
    endcase
  endfunction

  // Only a write whose chop is fixed by the stored setting starts early.
  function automatic logic resolve_early(len_mode_e m, logic is_write);
    resolve_early = is_write && (m == LEN_FIX4);
  endfunction
endpackage

// File: rtl/bos_mode_reg.sv
module bos_mode_reg
  import bos_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic [1:0] len_in,
  input  logic      ord_in,
  output len_mode_e mode_len,
  output ord_e      mode_ord
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_len <= LEN_FIX8;
      mode_ord <= ORD_SEQ;
    end else if (load) begin
      mode_len <= len_mode_e'(len_in);
      mode_ord <= ord_e'(ord_in);
    end
  end

  AST_MODE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(mode_len) && $stable(mode_ord))); // R1
endmodule

// File: rtl/bos_cmd_ctrl.sv
module bos_cmd_ctrl
  import bos_pkg::*;
#(
  parameter int COL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_bl8,
  input  len_mode_e        mode_len,
  input  ord_e             mode_ord,
  output logic             cmd_ready,
  output logic             cmd_err,
  output logic             active,
  output logic [COL_W-1:0] beat_idx,
  output logic             ctx_write,
  output logic [COL_W-1:0] ctx_col,
  output logic             ctx_chop,
  output logic             ctx_early,
  output ord_e             ctx_ord
);
  localparam logic [COL_W-1:0] LAST_IDX = {COL_W{1'b1}};

  logic accept;
  logic on_last;

  assign on_last   = active && (beat_idx == LAST_IDX);
  assign cmd_ready = !active || on_last;
  assign accept    = cmd_valid && cmd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      beat_idx  <= '0;
      cmd_err   <= 1'b0;
      ctx_write <= 1'b0;
      ctx_col   <= '0;
      ctx_chop  <= 1'b0;
      ctx_early <= 1'b0;
      ctx_ord   <= ORD_SEQ;
    end else begin
      cmd_err <= cmd_valid && !cmd_ready;
      if (accept) begin
        active    <= 1'b1;
        beat_idx  <= '0;
        ctx_write <= cmd_write;
        ctx_col   <= cmd_col;
        ctx_chop  <= resolve_chop(mode_len, cmd_bl8);
        ctx_early <= resolve_early(mode_len, cmd_write);
        ctx_ord   <= mode_ord;
      end else if (active) begin
        if (on_last) begin
          active   <= 1'b0;
          beat_idx <= '0;
        end else begin
          beat_idx <= beat_idx + 1'b1;
        end
      end
    end
  end

  AST_BUSY_CMD_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (active && beat_idx == COL_W'($past(beat_idx) + 1'b1))); // R11

  AST_ACCEPT_STARTS_BEAT0: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (active && beat_idx == '0)); // R10
endmodule

// File: rtl/bos_order_gen.sv
module bos_order_gen
  import bos_pkg::*;
#(
  parameter int COL_W         = 3,
  parameter int WR_START_BEAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [COL_W-1:0] beat_idx,
  input  logic             ctx_write,
  input  logic [COL_W-1:0] ctx_col,
  input  logic             ctx_chop,
  input  logic             ctx_early,
  input  ord_e             ctx_ord,
  output logic [COL_W-1:0] col,
  output logic             data,
  output logic             drive,
  output logic             last,
  output logic             wr_start
);
  localparam int               TOP      = COL_W - 1;
  localparam logic [COL_W-1:0] LAST_IDX = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] WS_NORM  = COL_W'(WR_START_BEAT);
  localparam logic [COL_W-1:0] WS_EARLY = COL_W'(WR_START_BEAT - 2);

  logic [COL_W-1:0] seq_col;
  logic [COL_W-1:0] intlv_col;
  logic [COL_W-1:0] rd_col;
  logic [COL_W-1:0] wr_col;
  logic             in_head;

  // Sequential: the top bit toggles by half, the low bits wrap inside the group.
  assign seq_col[TOP]     = ctx_col[TOP] ^ beat_idx[TOP];
  assign seq_col[TOP-1:0] = ctx_col[TOP-1:0] + beat_idx[TOP-1:0];
  assign intlv_col        = ctx_col ^ beat_idx;
  assign rd_col           = (ctx_ord == ORD_INTLV) ? intlv_col : seq_col;
  assign wr_col           = ctx_chop ? {ctx_col[TOP], beat_idx[TOP-1:0]} : beat_idx;
  assign in_head          = !beat_idx[TOP];

  always_comb begin
    data     = active && (!ctx_chop || in_head);
    drive    = data && !ctx_write;
    col      = data ? (ctx_write ? wr_col : rd_col) : '0;
    last     = active && (beat_idx == LAST_IDX);
    wr_start = active && ctx_write &&
               (beat_idx == (ctx_early ? WS_EARLY : WS_NORM));
  end

  AST_INTLV_XORS_BACK: assert property (@(posedge clk) disable iff (rst)
    (data && !ctx_write && ctx_ord == ORD_INTLV) |-> ((col ^ beat_idx) == ctx_col)); // R4

  AST_SEQ_LOW_STEPS: assert property (@(posedge clk) disable iff (rst)
    (data && !ctx_write && ctx_ord == ORD_SEQ && beat_idx != '0)
      |-> (col[TOP-1:0] == (COL_W-1)'($past(col[TOP-1:0]) + 1'b1))); // R3
endmodule

// File: rtl/burst_order_seq.sv
module burst_order_seq
  import bos_pkg::*;
#(
  parameter int COL_W         = 3,
  parameter int WR_START_BEAT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_load,
  input  logic [1:0]       mode_len,
  input  logic             mode_interleave,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_bl8,
  output logic             cmd_err,
  output logic             beat_valid,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_data,
  output logic             beat_drive,
  output logic             beat_last,
  output logic             wr_start
);
  len_mode_e        st_len;
  ord_e             st_ord;
  logic             active;
  logic [COL_W-1:0] beat_idx;
  logic             ctx_write;
  logic [COL_W-1:0] ctx_col;
  logic             ctx_chop;
  logic             ctx_early;
  ord_e             ctx_ord;

  bos_mode_reg u_mode (
    .clk      (clk),
    .rst      (rst),
    .load     (mode_load),
    .len_in   (mode_len),
    .ord_in   (mode_interleave),
    .mode_len (st_len),
    .mode_ord (st_ord)
  );

  bos_cmd_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_col   (cmd_col),
    .cmd_bl8   (cmd_bl8),
    .mode_len  (st_len),
    .mode_ord  (st_ord),
    .cmd_ready (cmd_ready),
    .cmd_err   (cmd_err),
    .active    (active),
    .beat_idx  (beat_idx),
    .ctx_write (ctx_write),
    .ctx_col   (ctx_col),
    .ctx_chop  (ctx_chop),
    .ctx_early (ctx_early),
    .ctx_ord   (ctx_ord)
  );

  bos_order_gen #(.COL_W(COL_W), .WR_START_BEAT(WR_START_BEAT)) u_order (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .beat_idx  (beat_idx),
    .ctx_write (ctx_write),
    .ctx_col   (ctx_col),
    .ctx_chop  (ctx_chop),
    .ctx_early (ctx_early),
    .ctx_ord   (ctx_ord),
    .col       (beat_col),
    .data      (beat_data),
    .drive     (beat_drive),
    .last      (beat_last),
    .wr_start  (wr_start)
  );

  assign beat_valid = active;

  AST_DRIVE_IN_BURST: assert property (@(posedge clk) disable iff (rst)
    beat_drive |-> (beat_valid && beat_data)); // R8

  AST_TAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_data) |-> (!beat_drive && beat_col == '0)); // R5

  AST_LAST_OPENS_READY: assert property (@(posedge clk) disable iff (rst)
    beat_last |-> cmd_ready); // R10

  AST_VALID_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(beat_valid) |-> $past(beat_last)); // R8

  AST_WRSTART_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_start |-> (beat_valid && !beat_drive)); // R9
endmodule

// File: tb/burst_order_seq_test.sv
`timescale 1ns/1ps
module burst_order_seq_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       mode_load, mode_interleave;
  logic [1:0] mode_len;
  logic       cmd_valid, cmd_write, cmd_bl8;
  logic [2:0] cmd_col;
  logic       cmd_ready, cmd_err, beat_valid, beat_data, beat_drive, beat_last, wr_start;
  logic [2:0] beat_col;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  burst_order_seq uut (
    .clk(clk), .rst(rst), .mode_load(mode_load), .mode_len(mode_len),
    .mode_interleave(mode_interleave), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_col(cmd_col), .cmd_bl8(cmd_bl8), .cmd_err(cmd_err),
    .beat_valid(beat_valid), .beat_col(beat_col), .beat_data(beat_data),
    .beat_drive(beat_drive), .beat_last(beat_last), .wr_start(wr_start)
  );

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic is_chop(input logic [1:0] len, input logic bl8);
    return (len == 2'b10) || (len == 2'b01 && !bl8);
  endfunction

  // Expected column for beat i, from the requirement formulas.
  function automatic logic [2:0] exp_col(input logic wr, input logic intl, input logic chop,
                                         input logic [2:0] c, input int i);
    logic [2:0] b;
    b = 3'(i);
    if (chop && i >= 4) return 3'd0;
    if (wr) return chop ? {c[2], b[1:0]} : b;
    if (intl) return c ^ b;
    return {c[2] ^ b[2], 2'(c[1:0] + b[1:0])};
  endfunction

  task automatic load_mode(input logic [1:0] len, input logic intl);
    mode_load = 1'b1; mode_len = len; mode_interleave = intl;
    @(negedge clk);
    mode_load = 1'b0;
  endtask

  // Offer a command at a negedge; returns at the negedge where beat 0 shows.
  task automatic issue(input logic wr, input logic [2:0] c, input logic bl8);
    cmd_valid = 1'b1; cmd_write = wr; cmd_col = c; cmd_bl8 = bl8;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Check beats from..7 against the expected order and flags.
  task automatic beats(input logic wr, input logic intl, input logic [1:0] len,
                       input logic bl8, input logic [2:0] c, input int from, input string tag);
    logic chop;
    int   ws;
    logic [6:0] act, exp;
    chop = is_chop(len, bl8);
    ws = !wr ? -1 : (len == 2'b10 ? 2 : 4);
    for (int i = from; i < 8; i++) begin
      exp = {1'b1, exp_col(wr, intl, chop, c, i), (!chop || i < 4),
             (!wr && (!chop || i < 4)), (i == 7)};
      act = {beat_valid, beat_col, beat_data, beat_drive, beat_last};
      check(act == exp, $sformatf("%s R8 beat%0d", tag, i), 32'(act), 32'(exp));
      check(wr_start == (i == ws), $sformatf("R9 wr_start beat%0d", i), 32'(wr_start),
            32'(i == ws));
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; mode_load = 0; mode_len = 0; mode_interleave = 0;
    cmd_valid = 0; cmd_write = 0; cmd_col = 0; cmd_bl8 = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check({beat_valid, beat_drive, cmd_ready, cmd_err} == 4'b0010, "R12 idle outputs",
          32'({beat_valid, beat_drive, cmd_ready, cmd_err}), 32'h2);
    // No mode load: the stored setting must be fixed eight, sequential (R12, R3).
    issue(1'b0, 3'd5, 1'b0);
    beats(1'b0, 1'b0, 2'b00, 1'b0, 3'd5, 0, "R12 R3 default");
    check(!beat_valid, "R8 valid drops after eighth beat", 32'(beat_valid), 0);
  endtask

  task automatic t_sweep();
    string tag;
    logic  chop;
    for (int o = 0; o < 2; o++)
      for (int l = 0; l < 4; l++) begin
        load_mode(2'(l), 1'(o));
        for (int b = 0; b < 2; b++)
          for (int w = 0; w < 2; w++)
            for (int c = 0; c < 8; c++) begin
              chop = is_chop(2'(l), 1'(b));
              tag = w != 0 ? (chop ? "R7" : "R6") : (chop ? "R5" : (o != 0 ? "R4" : "R3"));
              if (l == 1) tag = {"R2 ", tag};
              if (l == 3) tag = {"R1 ", tag};
              check(cmd_ready, "R10 ready when idle", 32'(cmd_ready), 1);
              issue(1'(w), 3'(c), 1'(b));
              beats(1'(w), 1'(o), 2'(l), 1'(b), 3'(c), 0, tag);
            end
      end
  endtask

  task automatic t_busy();
    load_mode(2'b00, 1'b0);
    issue(1'b0, 3'd0, 1'b1);
    beats(1'b0, 1'b0, 2'b00, 1'b1, 3'd0, 0, "R11 pre") ;
    // Second burst: drop a command at beat 3.
    issue(1'b0, 3'd0, 1'b1);
    repeat (3) @(negedge clk);
    check(!cmd_ready, "R11 ready low mid-burst", 32'(cmd_ready), 0);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 3'd7; cmd_bl8 = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(cmd_err, "R11 error pulse", 32'(cmd_err), 1);
    beats(1'b0, 1'b0, 2'b00, 1'b1, 3'd0, 4, "R11 burst unchanged");
    check(!cmd_err && !beat_valid, "R11 no extra burst",
          32'({cmd_err, beat_valid}), 0);
  endtask

  task automatic t_b2b();
    load_mode(2'b00, 1'b0);
    issue(1'b0, 3'd2, 1'b1);
    repeat (7) @(negedge clk);
    check(cmd_ready && beat_last, "R10 ready on last beat",
          32'({cmd_ready, beat_last}), 3);
    issue(1'b1, 3'd3, 1'b1);
    check(!cmd_err, "R10 no error on last-beat accept", 32'(cmd_err), 0);
    beats(1'b1, 1'b0, 2'b00, 1'b1, 3'd3, 0, "R10 R6 back-to-back");
  endtask

  task automatic t_mode_mid();
    load_mode(2'b00, 1'b0);
    issue(1'b0, 3'd1, 1'b1);
    beats(1'b0, 1'b0, 2'b00, 1'b1, 3'd1, 0, "R1 before");
    issue(1'b0, 3'd1, 1'b1);
    beats(1'b0, 1'b0, 2'b00, 1'b1, 3'd1, 0, "R1 pre-load part");
    issue(1'b0, 3'd1, 1'b1);
    mode_load = 1'b1; mode_len = 2'b10; mode_interleave = 1'b1;
    @(negedge clk);
    mode_load = 1'b0;
    beats(1'b0, 1'b0, 2'b00, 1'b1, 3'd1, 1, "R1 load mid-burst ignored");
    issue(1'b0, 3'd1, 1'b1);
    beats(1'b0, 1'b1, 2'b10, 1'b1, 3'd1, 0, "R1 R4 R5 new setting");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_sweep();
    t_busy();
    t_b2b();
    t_mode_mid();
    summary();
    $finish;
  end
endmodule